// File: doc/BRIEF.md
# Threshold-Qualified Event Counter

This block is one programmable counter that watches a shared cache and its request tracker. A control word picks an event source, a unit mask, a per-cycle threshold and two qualifiers: invert and rising-edge. Every cycle the selected source gives a number of occurrences. That number is either added straight to a 48-bit accumulator or turned into a pass/fail condition by comparing it with the threshold. Software can load the accumulator and the control word, and read both back, through plain write-strobe and read-data ports.

Three sources are decoded. The cache-lookup source counts lookup lanes that match both the line state and the request type selected in the unit mask. The occupancy source adds the tracker's valid-entry count. The allocation source adds the number of tracker entries allocated in the cycle. A parameter gives the counter's index among its siblings. Only index 0 accepts the occupancy source.

Top module: `thresh_evt_counter`

## Requirements
- R1: The control word holds the event code in bits 7:0, the unit mask in bits 15:8, edge in bit 18, enable in bit 22, invert in bit 23 and the threshold in bits 31:24. `cfg_rdata` returns these fields with every other bit at 0. A write to the control word takes effect from the cycle after its strobe.
- R2: While enable is 0 and no software load is made, the accumulator keeps its value.
- R3: With a nonzero threshold and invert clear, the accumulator gains 1 in each cycle whose event count is at least the threshold, and 0 in other cycles.
- R4: With a nonzero threshold and invert set, the accumulator gains 1 in each cycle whose event count is strictly below the threshold.
- R5: With edge set, the accumulator gains 1 only in a cycle where the qualified condition is true and was false in the previous counting cycle. The remembered condition is false after reset and in any cycle where the counter is disabled or the selection is invalid.
- R6: With a zero threshold, invert has no effect. The accumulator gains the raw event count each cycle. With edge also set, the qualified condition is "count is nonzero" and the accumulator gains 1 on each rise of that condition.
- R7: Event code 0x10 counts valid lookup lanes. Unit mask bits 0 to 3 accept line states M, E, S and I (`lk_state` codes 0, 1, 2, 3). Bit 4 accepts core reads (`lk_kind` 0), bit 5 core writes (kind 1), bit 6 external snoops (kind 2) and bit 7 any kind (0 to 3). A lane counts only if both its state and its kind are accepted. If either nibble of the mask is zero, nothing is counted.
- R8: Event code 0x20 adds `trk_occ` each cycle, but only when the parameter `CTR_IDX` is 0. On any other index that code never increments.
- R9: Event code 0x21 adds the number of set bits in `trk_alloc`. The unit mask is ignored for codes 0x20 and 0x21.
- R10: Any other event code never increments the accumulator.
- R11: The accumulator is 48 bits wide and wraps silently modulo 2^48.
- R12: A strobe on `cnt_wr` loads `cnt_wdata` into the accumulator at the next edge. It takes priority over an increment in the same cycle.
- R13: After reset the accumulator and the control word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Control word read value |
| cnt_wr | input | 1 | Accumulator load strobe |
| cnt_wdata | input | 48 | Accumulator load value |
| cnt_rdata | output | 48 | Accumulator value |
| lk_vld | input | LANES (4) | Lookup lane valid, one bit per lane |
| lk_state | input | 2*LANES (8) | Line state per lane: 0 M, 1 E, 2 S, 3 I |
| lk_kind | input | 2*LANES (8) | Request kind per lane: 0 read, 1 write, 2 snoop, 3 other |
| trk_occ | input | OCC_W (6) | Tracker valid-entry count this cycle |
| trk_alloc | input | ALLOC_W (4) | Tracker allocation strobes this cycle |

## Verification
The bench builds two copies with default widths: four lookup lanes, four allocation strobes and a 6-bit occupancy count. One copy has `CTR_IDX` 0 and the other has `CTR_IDX` 1, and both receive identical stimulus. With two copies, a single run shows occupancy being accepted on one counter and rejected on the other. The 6-bit occupancy count allows multi-unit increments large enough to push a preloaded accumulator across the 48-bit wrap in one cycle. Four lanes with mixed states and kinds are enough to show each mask nibble filtering on its own.

// File: rtl/tec_pkg.sv
package tec_pkg;

  localparam logic [7:0] EV_LOOKUP = 8'h10;
  localparam logic [7:0] EV_OCC    = 8'h20;
  localparam logic [7:0] EV_ALLOC  = 8'h21;

  typedef struct packed {
    logic [7:0] thr;
    logic       inv;
    logic       en;
    logic       edg;
    logic [7:0] umask;
    logic [7:0] code;
  } tec_cfg_t;

  // Control word layout to fields.
  function automatic tec_cfg_t cfg_from_word(input logic [31:0] w);
    tec_cfg_t c;
    c.code  = w[7:0];
    c.umask = w[15:8];
    c.edg   = w[18];
    c.en    = w[22];
    c.inv   = w[23];
    c.thr   = w[31:24];
    return c;
  endfunction

  function automatic logic [31:0] word_from_cfg(input tec_cfg_t c);
    return {c.thr, c.inv, c.en, 3'b000, c.edg, 2'b00, c.umask, c.code};
  endfunction

  // Lookup lane match: state nibble AND kind nibble (bit 7 = any kind).
  function automatic logic lookup_hit(input logic [7:0] um,
                                      input logic [1:0] st,
                                      input logic [1:0] kd);
    logic [3:0] sg;
    logic [3:0] kg;
    sg = um[3:0];
    kg = um[7:4];
    return sg[st] & (kg[3] | kg[kd]);
  endfunction

endpackage

// File: rtl/tec_select.sv
module tec_select
  import tec_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int ALLOC_W = 4,
  parameter int OCC_W   = 6,
  parameter int EV_W    = 6,
  parameter int CTR_IDX = 0
) (
  input  tec_cfg_t             cfg,
  input  logic [LANES-1:0]     lk_vld,
  input  logic [2*LANES-1:0]   lk_state,
  input  logic [2*LANES-1:0]   lk_kind,
  input  logic [OCC_W-1:0]     trk_occ,
  input  logic [ALLOC_W-1:0]   trk_alloc,
  output logic [EV_W-1:0]      ev_n,
  output logic                 ev_valid
);

  localparam bit OCC_ALLOWED = (CTR_IDX == 0);

  function automatic logic [EV_W-1:0] ones_in(input logic [ALLOC_W-1:0] v);
    logic [EV_W-1:0] s;
    s = '0;
    for (int i = 0; i < ALLOC_W; i++) s = s + EV_W'(v[i]);
    return s;
  endfunction

  logic [LANES-1:0] lane_hit;
  logic [EV_W-1:0]  lookup_n;
  logic             groups_ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_hit[g] = lk_vld[g] &
                         lookup_hit(cfg.umask, lk_state[2*g +: 2], lk_kind[2*g +: 2]);
  end

  always_comb begin
    lookup_n = '0;
    for (int i = 0; i < LANES; i++) lookup_n = lookup_n + EV_W'(lane_hit[i]);
  end

  assign groups_ok = (cfg.umask[3:0] != 4'h0) && (cfg.umask[7:4] != 4'h0);

  always_comb begin
    ev_n     = '0;
    ev_valid = 1'b0;
    unique case (cfg.code)
      EV_LOOKUP: begin
        ev_valid = groups_ok;
        ev_n     = lookup_n;
      end
      EV_OCC: begin
        ev_valid = OCC_ALLOWED;
        ev_n     = EV_W'(trk_occ);
      end
      EV_ALLOC: begin
        ev_valid = 1'b1;
        ev_n     = ones_in(trk_alloc);
      end
      default: ;
    endcase
  end

  // R8: occupancy selection is refused away from index 0.
  always_comb begin
    if (cfg.code == EV_OCC && CTR_IDX != 0)
      a_r8_occ_idx0_only: assert (!ev_valid);
  end

  // R7: a lookup selection with an empty mask nibble never validates.
  always_comb begin
    if (cfg.code == EV_LOOKUP && (cfg.umask[3:0] == 4'h0 || cfg.umask[7:4] == 4'h0))
      a_r7_empty_group: assert (!ev_valid);
  end

endmodule

// File: rtl/tec_qualify.sv
module tec_qualify
  import tec_pkg::*;
#(
  parameter int EV_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tec_cfg_t        cfg,
  input  logic [EV_W-1:0] ev_n,
  input  logic            ev_valid,
  output logic [EV_W-1:0] inc,
  output logic            active
);

  localparam int CW = (EV_W > 8) ? EV_W : 8;

  // Threshold condition: nonzero count when thr==0, else (inverted) compare.
  function automatic logic qual_cond(input logic [EV_W-1:0] n,
                                     input logic [7:0] thr, input logic inv);
    logic ge;
    ge = CW'(n) >= CW'(thr);
    if (thr == 8'h00) return n != '0;
    return inv ? !ge : ge;
  endfunction

  logic cond;
  logic prev_q;
  logic rise;

  assign active = cfg.en & ev_valid;
  assign cond   = qual_cond(ev_n, cfg.thr, cfg.inv);
  assign rise   = cond & ~prev_q;

  always_comb begin
    if (!active)              inc = '0;
    else if (cfg.edg)         inc = EV_W'(rise);
    else if (cfg.thr == 8'h0) inc = ev_n;
    else                      inc = EV_W'(cond);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= active & cond;
  end

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.thr != 8'h0 || cfg.edg) |-> (inc <= EV_W'(1)));

  a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.edg && inc != '0) |=> (!cfg.edg || inc == '0));

endmodule

// File: rtl/tec_accum.sv
module tec_accum #(
  parameter int CTR_W = 48,
  parameter int EV_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTR_W-1:0] wdata,
  input  logic             step_en,
  input  logic [EV_W-1:0]  inc,
  output logic [CTR_W-1:0] count
);

  localparam int PAD = CTR_W - EV_W;

  function automatic logic [CTR_W-1:0] wrap_add(input logic [CTR_W-1:0] a,
                                                input logic [EV_W-1:0] b);
    return a + {{PAD{1'b0}}, b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (wr)      count <= wdata;
    else if (step_en) count <= wrap_add(count, inc);
  end

  a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (count == $past(wdata)));

  a_r11_bounded_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !step_en) |=> $stable(count));

endmodule

// File: rtl/thresh_evt_counter.sv
module thresh_evt_counter
  import tec_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int ALLOC_W = 4,
  parameter int OCC_W   = 6,
  parameter int CTR_W   = 48,
  parameter int CTR_IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic                 cnt_wr,
  input  logic [CTR_W-1:0]     cnt_wdata,
  output logic [CTR_W-1:0]     cnt_rdata,
  input  logic [LANES-1:0]     lk_vld,
  input  logic [2*LANES-1:0]   lk_state,
  input  logic [2*LANES-1:0]   lk_kind,
  input  logic [OCC_W-1:0]     trk_occ,
  input  logic [ALLOC_W-1:0]   trk_alloc
);

  localparam int MAXL = (LANES > ALLOC_W) ? LANES : ALLOC_W;
  localparam int LW   = $clog2(MAXL + 1);
  localparam int EV_W = (OCC_W > LW) ? OCC_W : LW;

  tec_cfg_t        cfg_q;
  logic [EV_W-1:0] ev_n;
  logic            ev_valid;
  logic [EV_W-1:0] inc;
  logic            active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_from_word(cfg_wdata);
  end

  assign cfg_rdata = word_from_cfg(cfg_q);

  tec_select #(
    .LANES(LANES), .ALLOC_W(ALLOC_W), .OCC_W(OCC_W), .EV_W(EV_W), .CTR_IDX(CTR_IDX)
  ) u_sel (
    .cfg(cfg_q), .lk_vld(lk_vld), .lk_state(lk_state), .lk_kind(lk_kind),
    .trk_occ(trk_occ), .trk_alloc(trk_alloc), .ev_n(ev_n), .ev_valid(ev_valid)
  );

  tec_qualify #(.EV_W(EV_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .ev_n(ev_n), .ev_valid(ev_valid),
    .inc(inc), .active(active)
  );

  tec_accum #(.CTR_W(CTR_W), .EV_W(EV_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .wr(cnt_wr), .wdata(cnt_wdata),
    .step_en(active), .inc(inc), .count(cnt_rdata)
  );

  a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !cfg_q.en) |=> $stable(cnt_rdata));

  a_r10_unknown_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && cfg_q.code != EV_LOOKUP && cfg_q.code != EV_OCC && cfg_q.code != EV_ALLOC)
    |=> $stable(cnt_rdata));

endmodule

// File: tb/tb_thresh_evt_counter.sv
`timescale 1ns/1ps
module tb_thresh_evt_counter;

  localparam logic [31:0] FIELD_MASK = 32'hFFC4_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        cnt_wr = 1'b0;
  logic [47:0] cnt_wdata = '0;
  logic [3:0]  lk_vld = '0;
  logic [7:0]  lk_state = '0;
  logic [7:0]  lk_kind = '0;
  logic [5:0]  trk_occ = '0;
  logic [3:0]  trk_alloc = '0;
  logic [31:0] rd0_cfg, rd1_cfg;
  logic [47:0] rd0_cnt, rd1_cnt;

  always #2.5 clk = ~clk;

  thresh_evt_counter #(.CTR_IDX(0)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(rd0_cfg),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_rdata(rd0_cnt), .lk_vld(lk_vld),
    .lk_state(lk_state), .lk_kind(lk_kind), .trk_occ(trk_occ), .trk_alloc(trk_alloc));

  thresh_evt_counter #(.CTR_IDX(1)) dut_idx1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(rd1_cfg),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_rdata(rd1_cnt), .lk_vld(lk_vld),
    .lk_state(lk_state), .lk_kind(lk_kind), .trk_occ(trk_occ), .trk_alloc(trk_alloc));

  typedef struct {
    logic [47:0] c0;
    logic [47:0] c1;
    logic [31:0] cf;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  string       cur_tag = "R13";
  logic [47:0] mc[2];
  logic        mprev[2];
  logic [31:0] mcfg[2];

  function automatic logic [31:0] cw(logic [7:0] code, logic [7:0] um, logic edg,
                                     logic en, logic inv, logic [7:0] thr);
    logic [31:0] w;
    w = '0;
    w[7:0] = code; w[15:8] = um; w[18] = edg; w[22] = en; w[23] = inv; w[31:24] = thr;
    return w;
  endfunction

  // Event count per requirement R7/R8/R9/R10; -1 means nothing may count.
  function automatic int model_n(logic [31:0] c, int idx);
    int n;
    n = 0;
    case (c[7:0])
      8'h10: begin
        if (c[11:8] == 0 || c[15:12] == 0) return -1;
        for (int i = 0; i < 4; i++) begin
          int st, kd;
          st = int'(lk_state[2*i +: 2]);
          kd = int'(lk_kind[2*i +: 2]);
          if (lk_vld[i] && c[8 + st] && (c[15] || (kd < 3 && c[12 + kd]))) n++;
        end
        return n;
      end
      8'h20: return (idx == 0) ? int'(trk_occ) : -1;
      8'h21: begin
        for (int i = 0; i < 4; i++) if (trk_alloc[i]) n++;
        return n;
      end
      default: return -1;
    endcase
  endfunction

  task automatic step();
    exp_t e;
    for (int k = 0; k < 2; k++) begin
      int n, thr, add;
      bit cond, act;
      n    = model_n(mcfg[k], k);
      act  = mcfg[k][22] && (n >= 0);
      thr  = int'(mcfg[k][31:24]);
      if (thr == 0) cond = (n > 0);
      else if (mcfg[k][23]) cond = (n < thr);
      else cond = (n >= thr);
      add = 0;
      if (act) begin
        if (mcfg[k][18]) add = (cond && !mprev[k]) ? 1 : 0;
        else if (thr == 0) add = n;
        else add = cond ? 1 : 0;
      end
      if (cnt_wr) mc[k] = cnt_wdata;
      else mc[k] = mc[k] + 48'(add);
      mprev[k] = act && cond;
      if (cfg_wr) mcfg[k] = cfg_wdata & FIELD_MASK;
    end
    e.c0 = mc[0]; e.c1 = mc[1]; e.cf = mcfg[0]; e.tag = cur_tag;
    sb.push_back(e);
    @(posedge clk);
    #2;
    cfg_wr = 1'b0;
    cnt_wr = 1'b0;
  endtask

  task automatic wcfg(logic [31:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; step();
  endtask

  task automatic alloc(logic [3:0] v);
    trk_alloc = v; step();
  endtask

  // Monitor: pop one expected item per edge and compare.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (rd0_cnt !== e.c0 || rd1_cnt !== e.c1 || rd0_cfg !== e.cf) begin
        fails++;
        $display("FAIL %s: cnt0=%h cnt1=%h cfg=%h expected cnt0=%h cnt1=%h cfg=%h",
                 e.tag, rd0_cnt, rd1_cnt, rd0_cfg, e.c0, e.c1, e.cf);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin mc[k] = '0; mprev[k] = 1'b0; mcfg[k] = '0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // R13: reset state
    checks++;
    if (rd0_cnt !== 48'h0 || rd1_cnt !== 48'h0) begin
      fails++; $display("FAIL R13: cnt0=%h cnt1=%h expected 0", rd0_cnt, rd1_cnt);
    end
    checks++;
    if (rd0_cfg !== 32'h0) begin
      fails++; $display("FAIL R13: cfg=%h expected 0", rd0_cfg);
    end

    // R1: field readback with reserved bits dropped
    cur_tag = "R1";
    wcfg(32'hFFFF_FFFF);
    // R10: unknown code 0xFF enabled, stimulus present, no count
    cur_tag = "R10";
    trk_occ = 6'd9; lk_vld = 4'hF;
    alloc(4'b1111); alloc(4'b0011);
    lk_vld = 4'h0; trk_occ = '0;

    // R9: allocation strobe count, raw add
    cur_tag = "R9";
    wcfg(cw(8'h21, 8'h00, 0, 1, 0, 8'd0));
    alloc(4'b0001); alloc(4'b1011); alloc(4'b1111); alloc(4'b0000);

    // R6: zero threshold ignores invert
    cur_tag = "R6";
    wcfg(cw(8'h21, 8'h5A, 0, 1, 1, 8'd0));
    alloc(4'b0011); alloc(4'b0111);

    // R3: threshold 2
    cur_tag = "R3";
    wcfg(cw(8'h21, 8'h00, 0, 1, 0, 8'd2));
    alloc(4'b0001); alloc(4'b0011); alloc(4'b0111); alloc(4'b1111); alloc(4'b0000);

    // R4: inverted threshold 2
    cur_tag = "R4";
    wcfg(cw(8'h21, 8'h00, 0, 1, 1, 8'd2));
    alloc(4'b0001); alloc(4'b0011); alloc(4'b0000); alloc(4'b1111);

    // R5: edge with threshold 2
    cur_tag = "R5";
    wcfg(cw(8'h21, 8'h00, 1, 1, 0, 8'd2));
    alloc(4'b0011); alloc(4'b0111); alloc(4'b1111); alloc(4'b0001);
    alloc(4'b0011); alloc(4'b0011);

    // R6: edge with zero threshold counts rises of nonzero
    cur_tag = "R6";
    wcfg(cw(8'h21, 8'h00, 1, 1, 0, 8'd0));
    alloc(4'b0001); alloc(4'b0001); alloc(4'b0000); alloc(4'b1000); alloc(4'b1100);
    trk_alloc = '0;

    // R7: lookup lanes: states M,E,S,I; kinds read,read,write,other
    cur_tag = "R7";
    lk_state = {2'd3, 2'd2, 2'd1, 2'd0};
    lk_kind  = {2'd3, 2'd1, 2'd0, 2'd0};
    lk_vld   = 4'b1111;
    wcfg(cw(8'h10, 8'b0001_0011, 0, 1, 0, 8'd0));
    step(); step();
    wcfg(cw(8'h10, 8'b1000_1100, 0, 1, 0, 8'd0));
    step();
    lk_vld = 4'b0101; step();
    lk_vld = 4'b1111;
    wcfg(cw(8'h10, 8'b0110_0001, 0, 1, 0, 8'd0));
    step();
    wcfg(cw(8'h10, 8'b0000_1111, 0, 1, 0, 8'd0));
    step();
    wcfg(cw(8'h10, 8'b1111_0000, 0, 1, 0, 8'd0));
    step();
    lk_vld = 4'b0000;

    // R8: occupancy only on index 0
    cur_tag = "R8";
    wcfg(cw(8'h20, 8'h00, 0, 1, 0, 8'd0));
    trk_occ = 6'd5; step();
    trk_occ = 6'd17; step();
    trk_occ = 6'd0; step();

    // R2: disabled counter holds
    cur_tag = "R2";
    wcfg(cw(8'h21, 8'h00, 0, 0, 0, 8'd0));
    alloc(4'b1111); alloc(4'b0111);

    // R12: load wins over a same-cycle increment
    cur_tag = "R12";
    wcfg(cw(8'h21, 8'h00, 0, 1, 0, 8'd0));
    cnt_wr = 1'b1; cnt_wdata = 48'd100; alloc(4'b1111);
    alloc(4'b1111);

    // R11: wrap modulo 2^48 with a multi-unit occupancy increment
    cur_tag = "R11";
    trk_alloc = '0;
    wcfg(cw(8'h20, 8'h00, 0, 1, 0, 8'd0));
    cnt_wr = 1'b1; cnt_wdata = 48'hFFFF_FFFF_FFFE; step();
    trk_occ = 6'd3; step();
    trk_occ = 6'd0; step();

    done = 1'b1;
    finish_run();
  end

endmodule